// File: doc/BRIEF.md
# Strided Per-Context Stream Address Generator

This block turns stream loads and stores issued by an interleaved (barrel) processor into 32-bit-aligned byte addresses. Several hardware contexts run threads in rotation, and every thread touches each stream a fixed number of times. The block keeps one running element offset per context and per stream. When a thread is dispatched onto a context, it seeds that context's offsets from a per-stream "next thread start" accumulator. As a result, each thread works in its own contiguous slice of every stream, and consecutive threads' slices sit back to back, even though the hardware interleaves their accesses.

Before a job, software programs a base byte pointer and a thread stride for each stream. The stride is the count of accesses one thread makes to that stream. A job-start pulse then clears the accumulators. Each access returns `base + 4 * offset` one cycle later and advances that context's offset for that stream by one element. A global stall freezes all offset and accumulator state.

Top module: `stream_addr_gen`

## Requirements
- R1: After reset `addr_valid` is low, and every accumulator is zero, so a dispatch with no job start seeds offset 0 for every stream.
- R2: An unstalled `job_start` clears every stream's accumulator. A dispatch in the same cycle seeds offset 0 and leaves the accumulator equal to the stream's stride.
- R3: An unstalled dispatch to context c sets c's offset for every stream s to that stream's accumulator, and adds the stride of s to the accumulator.
- R4: An unstalled access (context c, stream s) makes `addr_out = base[s] + 4*offset[c][s]` valid on the next cycle. It then increments offset[c][s] by one.
- R5: An access changes only the offset entry of its own context and stream. Other contexts and streams keep their values.
- R6: A config write with `cfg_sel`=0 stores `cfg_wdata` as the base of stream `cfg_stream`, with bits [1:0] forced to 0. With `cfg_sel`=1 it stores the low OFF_W bits as that stream's stride. The new value is used from the next cycle on.
- R7: While `stall` is high, dispatch, access and job start have no effect on any offset or accumulator.
- R8: When a dispatch and an access name the same context in one cycle, the access uses the old offset and the dispatch's seeded value is kept.
- R9: `addr_valid` is high exactly in the cycle after an unstalled access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all offset and accumulator updates |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = base pointer, 1 = thread stride |
| cfg_stream | input | SID_W (2) | Stream selected by the write |
| cfg_wdata | input | ADDR_W (32) | Write data |
| job_start | input | 1 | Clears the next-thread-start accumulators |
| disp_valid | input | 1 | Thread dispatch event |
| disp_ctx | input | CTX_W (3) | Context receiving the new thread |
| acc_valid | input | 1 | Stream access request |
| acc_ctx | input | CTX_W (3) | Context making the access |
| acc_stream | input | SID_W (2) | Stream accessed |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | ADDR_W (32) | Byte address of the accessed element |

## Verification
Configuration, dispatch and job-start effects are visible from the next cycle. An address becomes valid one clock edge after its access is presented. The driver applies inputs on the falling edge and pushes each expected address into the queue at that moment. The monitor samples 1 ns after the following rising edge. It therefore always expects exactly the items pushed in the previous cycle. A valid output with an empty queue, or a queued item with no valid output, is reported as an R9 mismatch. A stalled access followed by the same access unstalled shows that the stall had no effect.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic {
        CFG_BASE   = 1'b0,
        CFG_STRIDE = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/sag_cfg_regs.sv
module sag_cfg_regs
    import sag_pkg::*;
#(
    parameter int NS = 4,
    parameter int AW = 32,
    parameter int OW = 30,
    localparam int SW = $clog2(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  cfg_sel_e               sel,
    input  logic [SW-1:0]          stream,
    input  logic [AW-1:0]          wdata,
    output logic [NS-1:0][AW-1:0]  base_o,
    output logic [NS-1:0][OW-1:0]  stride_o
);
    typedef struct packed {
        logic [NS-1:0][AW-1:0] base;
        logic [NS-1:0][OW-1:0] stride;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == CFG_BASE) cfg_d.base[stream] = {wdata[AW-1:2], 2'b00};
            else                 cfg_d.stride[stream] = wdata[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_o   = cfg_q.base;
    assign stride_o = cfg_q.stride;

    // R6: written base pointers are word aligned
    a_r6_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == CFG_BASE) |=> (cfg_q.base[$past(stream)][1:0] == 2'b00));
endmodule

// File: rtl/sag_start_accum.sv
module sag_start_accum #(
    parameter int NS = 4,
    parameter int OW = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic                   job_start,
    input  logic                   disp_valid,
    input  logic [NS-1:0][OW-1:0]  stride_i,
    output logic [NS-1:0][OW-1:0]  start_o
);
    typedef struct packed {
        logic [NS-1:0][OW-1:0] acc;
    } acc_state_t;

    acc_state_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        for (int s = 0; s < NS; s++) begin
            start_o[s] = job_start ? '0 : acc_q.acc[s];
            if (!stall) begin
                if (disp_valid)     acc_d.acc[s] = start_o[s] + stride_i[s];
                else if (job_start) acc_d.acc[s] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R7: accumulators frozen under stall
    a_r7_accum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(acc_q));
    // R2: a bare job start clears every accumulator
    a_r2_job_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (job_start && !stall && !disp_valid) |=> (acc_q == '0));
endmodule

// File: rtl/sag_offset_table.sv
module sag_offset_table #(
    parameter int NS = 4,
    parameter int NC = 8,
    parameter int OW = 30,
    localparam int SW = $clog2(NS),
    localparam int CW = $clog2(NC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic                   disp_valid,
    input  logic [CW-1:0]          disp_ctx,
    input  logic [NS-1:0][OW-1:0]  start_i,
    input  logic                   acc_valid,
    input  logic [CW-1:0]          acc_ctx,
    input  logic [SW-1:0]          acc_stream,
    output logic [OW-1:0]          off_o
);
    typedef struct packed {
        logic [NC-1:0][NS-1:0][OW-1:0] off;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;

    assign off_o = tbl_q.off[acc_ctx][acc_stream];

    always_comb begin
        tbl_d = tbl_q;
        if (!stall) begin
            if (acc_valid) tbl_d.off[acc_ctx][acc_stream] = off_o + 1'b1;
            if (disp_valid) begin
                for (int s = 0; s < NS; s++) tbl_d.off[disp_ctx][s] = start_i[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // R4: an access advances its entry by one element
    a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !stall && !(disp_valid && disp_ctx == acc_ctx))
        |=> (tbl_q.off[$past(acc_ctx)][$past(acc_stream)] == $past(off_o) + 1'b1));
    // R8: the dispatch seed wins for its context
    a_r8_dispatch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !stall) |=> (tbl_q.off[$past(disp_ctx)] == $past(start_i)));
    // R7: offsets frozen under stall
    a_r7_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(tbl_q));
endmodule

// File: rtl/stream_addr_gen.sv
module stream_addr_gen
    import sag_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_CTX     = 8,
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 30,
    localparam int SID_W = $clog2(NUM_STREAMS),
    localparam int CTX_W = $clog2(NUM_CTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [SID_W-1:0]  cfg_stream,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              job_start,
    input  logic              disp_valid,
    input  logic [CTX_W-1:0]  disp_ctx,
    input  logic              acc_valid,
    input  logic [CTX_W-1:0]  acc_ctx,
    input  logic [SID_W-1:0]  acc_stream,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out
);
    logic [NUM_STREAMS-1:0][ADDR_W-1:0] base;
    logic [NUM_STREAMS-1:0][OFF_W-1:0]  stride;
    logic [NUM_STREAMS-1:0][OFF_W-1:0]  start;
    logic [OFF_W-1:0]                   off;

    sag_cfg_regs #(.NS(NUM_STREAMS), .AW(ADDR_W), .OW(OFF_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel_e'(cfg_sel)),
        .stream(cfg_stream), .wdata(cfg_wdata), .base_o(base), .stride_o(stride)
    );

    sag_start_accum #(.NS(NUM_STREAMS), .OW(OFF_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .stall(stall), .job_start(job_start),
        .disp_valid(disp_valid), .stride_i(stride), .start_o(start)
    );

    sag_offset_table #(.NS(NUM_STREAMS), .NC(NUM_CTX), .OW(OFF_W)) i_table (
        .clk(clk), .rst_n(rst_n), .stall(stall), .disp_valid(disp_valid),
        .disp_ctx(disp_ctx), .start_i(start), .acc_valid(acc_valid),
        .acc_ctx(acc_ctx), .acc_stream(acc_stream), .off_o(off)
    );

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } out_state_t;

    out_state_t out_d, out_q;
    logic       fire;

    assign fire = acc_valid && !stall;

    always_comb begin
        out_d       = out_q;
        out_d.valid = fire;
        if (fire) out_d.addr = base[acc_stream] + (ADDR_W'(off) << 2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign addr_valid = out_q.valid;
    assign addr_out   = out_q.addr;

    // R9: one result per unstalled access, one cycle later
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !stall) |=> addr_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !stall) |=> !addr_valid);
    // R7: stalled cycles produce no address
    a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !addr_valid);
endmodule

// File: tb/test_stream_addr_gen.sv
`timescale 1ns/1ps
module test_stream_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        stall = 0, cfg_we = 0, cfg_sel = 0, job_start = 0;
    logic        disp_valid = 0, acc_valid = 0;
    logic [1:0]  cfg_stream = 0, acc_stream = 0;
    logic [2:0]  disp_ctx = 0, acc_ctx = 0;
    logic [31:0] cfg_wdata = 0;
    logic        addr_valid;
    logic [31:0] addr_out;

    always #2.5 clk = ~clk;

    stream_addr_gen i_stream_addr_gen (
        .clk(clk), .rst_n(rst_n), .stall(stall), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_stream(cfg_stream), .cfg_wdata(cfg_wdata), .job_start(job_start),
        .disp_valid(disp_valid), .disp_ctx(disp_ctx), .acc_valid(acc_valid),
        .acc_ctx(acc_ctx), .acc_stream(acc_stream), .addr_valid(addr_valid),
        .addr_out(addr_out)
    );

    typedef struct { logic [31:0] addr; string tag; } exp_t;
    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_base[4];
    logic [29:0] m_stride[4], m_acc[4];
    logic [29:0] m_off[8][4];

    task automatic step(bit job, bit disp, int dc, bit acc, int ac, int as, bit stl, string tag);
        exp_t e;
        logic [29:0] eff;
        @(negedge clk);
        cfg_we = 0; job_start = job; disp_valid = disp; disp_ctx = 3'(dc);
        acc_valid = acc; acc_ctx = 3'(ac); acc_stream = 2'(as); stall = stl;
        if (!stl) begin
            if (acc) begin
                e.addr = m_base[as] + {m_off[ac][as], 2'b00};
                e.tag  = tag;
                q.push_back(e);
                m_off[ac][as] = m_off[ac][as] + 1;
            end
            for (int s = 0; s < 4; s++) begin
                eff = job ? 30'd0 : m_acc[s];
                if (disp) begin
                    m_off[dc][s] = eff;
                    m_acc[s] = eff + m_stride[s];
                end else if (job) m_acc[s] = 0;
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic cfg(int s, bit sel, logic [31:0] v);
        @(negedge clk);
        job_start = 0; disp_valid = 0; acc_valid = 0; stall = 0;
        cfg_we = 1; cfg_sel = sel; cfg_stream = 2'(s); cfg_wdata = v;
        if (!sel) m_base[s] = {v[31:2], 2'b00};
        else      m_stride[s] = v[29:0];
    endtask

    // monitor: results are due one edge after the access
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (rst_n && !done) begin
                if (addr_valid) begin
                    if (q.size() == 0) begin
                        n_cmp++; n_bad++;
                        $display("FAIL R9 unexpected output: actual valid addr=%h expected none", addr_out);
                    end else begin
                        e = q.pop_front();
                        n_cmp++;
                        if (addr_out !== e.addr) begin
                            n_bad++;
                            $display("FAIL %s addr: actual=%h expected=%h", e.tag, addr_out, e.addr);
                        end
                    end
                end else if (q.size() != 0) begin
                    e = q.pop_front();
                    n_cmp++; n_bad++;
                    $display("FAIL R9 missing output (%s): actual valid=0 expected addr=%h", e.tag, e.addr);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            m_base[s] = 0; m_stride[s] = 0; m_acc[s] = 0;
            for (int c = 0; c < 8; c++) m_off[c][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_cmp++;
        if (addr_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual valid=%b expected=0", addr_valid);
        end
        // R6: configure bases (one misaligned) and strides
        cfg(0, 0, 32'h0000_1000);
        cfg(1, 0, 32'h0000_2003);
        cfg(2, 0, 32'h8000_0000);
        cfg(3, 0, 32'h0000_0040);
        cfg(0, 1, 32'd3);
        cfg(1, 1, 32'd1);
        cfg(2, 1, 32'd2);
        cfg(3, 1, 32'd0);
        idle();
        // R1: first dispatch without job start seeds zero
        step(0, 1, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 0, 1, 0, "R6");
        // R3: remaining contexts take consecutive slices
        for (int c = 1; c < 8; c++) step(0, 1, c, 0, 0, 0, 0, "R3");
        for (int k = 0; k < 3; k++)
            for (int c = 0; c < 8; c++) step(0, 0, 0, 1, c, (c + k) % 4, 0, "R3");
        // R5: interleave streams and contexts
        for (int c = 7; c >= 0; c--) step(0, 0, 0, 1, c, 2, 0, "R5");
        step(0, 0, 0, 1, 3, 0, 0, "R5");
        step(0, 0, 0, 1, 4, 0, 0, "R5");
        // R7: everything stalled, then the same access unstalled
        step(1, 1, 3, 1, 3, 0, 1, "R7");
        step(1, 1, 3, 1, 3, 0, 1, "R7");
        step(0, 0, 0, 1, 3, 0, 0, "R7");
        step(0, 1, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 1, 2, 0, "R7");
        // R8: dispatch and access to one context together
        step(0, 1, 2, 1, 2, 0, 0, "R8");
        step(0, 0, 0, 1, 2, 0, 0, "R8");
        // R2: job start with dispatch, then another dispatch
        step(1, 1, 5, 0, 0, 0, 0, "R2");
        for (int s = 0; s < 4; s++) step(0, 0, 0, 1, 5, s, 0, "R2");
        step(0, 1, 6, 0, 0, 0, 0, "R2");
        for (int s = 0; s < 4; s++) step(0, 0, 0, 1, 6, s, 0, "R2");
        // R2: bare job start, then dispatch
        step(1, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 7, 1, 6, 0, 0, "R2");
        step(0, 0, 0, 1, 7, 0, 0, "R2");
        // R6: base change takes effect next cycle
        cfg(3, 0, 32'h0001_0007);
        step(0, 0, 0, 1, 7, 3, 0, "R6");
        step(0, 0, 0, 1, 0, 3, 0, "R4");
        idle();
        idle();
        idle();
        done = 1;
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 leftover: actual=%0d pending expected=0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule